// File: doc/BRIEF.md
# Exception-Level Access Permission Checker

This block decides whether one memory access may proceed in a 64-bit translation regime and, if it may not, which fault class applies and which address is reported with it. Each request carries the current exception level, the access kind, the permission bits of the matching translation entry (a two-bit access field, an execute-never bit and a privileged-execute-never bit), the memory type and cacheability of the page, a prefetch hint, the access alignment requirement, the write-implies-never-execute control, the data virtual address and the program counter.

Requests enter on a valid/ready interface and results leave on a second valid/ready interface after one register stage. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. The result is held, unchanged, while `out_valid` is high and `out_ready` is low. In that state `in_ready` is low, so the upstream side must keep its request steady until it is taken. When the consumer takes a result on the same edge that a new request arrives, the stage accepts the new request with no bubble. Results leave in request order, one for each request.

The grant is decoded per exception level from the permission bits, with the write-implies-never-execute control removing execute rights from writable pages. A fixed-priority chain of fault checks then picks one fault class.

Top module: `el_access_checker`

## Requirements
- R1: A request is accepted on a rising edge with `in_valid` and `in_ready` high. While a result is presented with `out_ready` low, `in_ready` is low and `out_valid`, `out_grant`, `out_fault` and `out_addr` stay unchanged. Each accepted request yields exactly one result, in order.
- R2: While `rst_n` is low, `out_valid` and `in_ready` are low.
- R3: `in_kind` encodes 0 = read, 1 = write, 2 = execute (3 is never driven). At level 0, with index {ap[1], ap[0], xn, pxn}: indices 0, 1, 8 and 9 allow execute only. Indices 4 and 5 allow read and write, and allow execute only when `in_wxn` is 0. Indices 6 and 7 allow read and write. Indices 12 and 13 allow read and execute. Indices 14 and 15 allow read only. Indices 2, 3, 10 and 11 allow nothing.
- R4: At level 1, with the same index: indices 0 and 2 allow read and write, and allow execute only when `in_wxn` is 0. Indices 1 and 3 to 7 allow read and write. Indices 8, 10, 12 and 14 allow read and execute. Indices 9, 11, 13 and 15 allow read only.
- R5: At levels 2 and 3, with index {ap[1], xn}: 0 allows read and write, and allows execute only when `in_wxn` is 0. 1 allows read and write. 2 allows read and execute. 3 allows read only.
- R6: `out_grant` is the R3 to R5 decision for the request's access kind. It is reported even when a fault class of R7 to R9 is selected.
- R7: A read or write with `in_normal` = 0 whose `in_vaddr` has any bit set below bit `in_align` gives `out_fault` = 2 (alignment). Normal memory and fetches never give this code.
- R8: A request with `in_prefetch` = 1 to a page with `in_noncache` = 1 gives `out_fault` = 3 (uncacheable prefetch).
- R9: An execute access with `in_pc[1:0]` non-zero gives `out_fault` = 1 (PC alignment), and `out_addr` = `in_pc`.
- R10: If none of R7 to R9 applies, a denied execute gives `out_fault` = 4 with `out_addr` = `in_pc`. A denied read or write gives `out_fault` = 5 with `out_addr` = `in_vaddr`. A granted access gives `out_fault` = 0 with `out_addr` = `in_vaddr`.
- R11: When several fault conditions hold at once, the priority is PC alignment, then alignment, then uncacheable prefetch, then permission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this edge |
| in_el | input | 2 | Current exception level |
| in_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| in_ap | input | 2 | Entry access permission field |
| in_xn | input | 1 | Entry execute-never bit |
| in_pxn | input | 1 | Entry privileged execute-never bit |
| in_normal | input | 1 | Page is Normal memory |
| in_noncache | input | 1 | Page is non-cacheable |
| in_prefetch | input | 1 | Request is a prefetch |
| in_align | input | ALIGN_W | log2 of required alignment in bytes |
| in_wxn | input | 1 | Writable pages are not executable |
| in_vaddr | input | VA_W | Data virtual address |
| in_pc | input | VA_W | Program counter of the access |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_grant | output | 1 | Permission decode decision |
| out_fault | output | 3 | Fault class: 0 none, 1 PC alignment, 2 alignment, 3 uncacheable prefetch, 4 fetch permission, 5 data permission |
| out_addr | output | VA_W | Address reported with the result |

## Verification
Two functions can fall in the same cycle in two ways. The first is fault ranking: one request can raise several fault conditions together, such as a misaligned PC on a non-executable, non-cacheable prefetch, or an unaligned read to device memory on a read-denied page. The bench sends such requests and expects only the highest-ranked code, with the grant bit still showing the table decision. The second is the stage taking a new request while the consumer stalls. A pseudo-random `out_ready` pattern is run against continuous traffic, and the scoreboard checks that no result is lost, duplicated or changed while stalled and that `in_ready` stays low during each stall.

// File: rtl/chk_pkg.sv
package chk_pkg;
  localparam int EL_COUNT = 4;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_PC_ALIGN  = 3'd1,
    FLT_ALIGN     = 3'd2,
    FLT_PF_UNCACHE = 3'd3,
    FLT_PERM_FETCH = 3'd4,
    FLT_PERM_DATA  = 3'd5
  } fault_e;
endpackage

// File: rtl/chk_grant_decode.sv
module chk_grant_decode
  import chk_pkg::*;
(
  input  logic [1:0] el,
  input  logic [1:0] kind,
  input  logic [1:0] ap,
  input  logic       xn,
  input  logic       pxn,
  input  logic       wxn,
  output logic       grant
);
  // per-level rights, bit 2 = read, bit 1 = write, bit 0 = execute
  logic [EL_COUNT-1:0][2:0] rights;

  for (genvar e = 0; e < EL_COUNT; e++) begin : g_el
    if (e == 0) begin : g_user
      logic w_ok;
      assign w_ok = ap[0] & ~ap[1];
      assign rights[e] = {ap[0], w_ok, ~xn & ~(w_ok & wxn)};
    end else if (e == 1) begin : g_kernel
      logic w_ok;
      logic user_writable;
      assign w_ok          = ~ap[1];
      assign user_writable = ap[0] & ~ap[1];
      assign rights[e] = {1'b1, w_ok, ~pxn & ~user_writable & ~(w_ok & wxn)};
    end else begin : g_high
      logic w_ok;
      assign w_ok = ~ap[1];
      assign rights[e] = {1'b1, w_ok, ~xn & ~(w_ok & wxn)};
    end
  end

  logic [2:0] sel;
  assign sel = rights[el];

  always_comb begin
    case (kind)
      KIND_WRITE: grant = sel[1];
      KIND_EXEC:  grant = sel[0];
      default:    grant = sel[2];
    endcase
  end
endmodule

// File: rtl/chk_align_probe.sv
module chk_align_probe #(
  parameter int VA_W    = 48,
  parameter int ALIGN_W = 3
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [ALIGN_W-1:0] align,
  output logic               misaligned
);
  localparam int MASK_W = (1 << ALIGN_W) - 1;

  logic [MASK_W-1:0] low_mask;

  for (genvar i = 0; i < MASK_W; i++) begin : g_mask
    assign low_mask[i] = ({1'b0, align} > (ALIGN_W+1)'(i));
  end

  assign misaligned = |(vaddr[MASK_W-1:0] & low_mask);
endmodule

// File: rtl/chk_fault_rank.sv
module chk_fault_rank
  import chk_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [1:0] pc_lo,
  input  logic       misaligned,
  input  logic       normal,
  input  logic       noncache,
  input  logic       prefetch,
  input  logic       grant,
  output fault_e     fault,
  output logic       use_pc
);
  logic is_fetch;
  assign is_fetch = (kind == KIND_EXEC);

  always_comb begin
    if (is_fetch && (pc_lo != 2'b00))
      fault = FLT_PC_ALIGN;
    else if (!is_fetch && !normal && misaligned)
      fault = FLT_ALIGN;
    else if (prefetch && noncache)
      fault = FLT_PF_UNCACHE;
    else if (!grant)
      fault = is_fetch ? FLT_PERM_FETCH : FLT_PERM_DATA;
    else
      fault = FLT_NONE;
  end

  assign use_pc = (fault == FLT_PC_ALIGN) || (fault == FLT_PERM_FETCH);
endmodule

// File: rtl/chk_out_stage.sv
module chk_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         held_q;
  logic [W-1:0] data_q;

  assign in_ready  = rst_n & (~held_q | out_ready);
  assign out_valid = held_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (in_ready) begin
      held_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data_q <= in_data;
  end

  // R1: a stalled result stays put
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1: no acceptance while a stalled result is held
  p_no_take_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/el_access_checker.sv
module el_access_checker
  import chk_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int ALIGN_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_el,
  input  logic [1:0]         in_kind,
  input  logic [1:0]         in_ap,
  input  logic               in_xn,
  input  logic               in_pxn,
  input  logic               in_normal,
  input  logic               in_noncache,
  input  logic               in_prefetch,
  input  logic [ALIGN_W-1:0] in_align,
  input  logic               in_wxn,
  input  logic [VA_W-1:0]    in_vaddr,
  input  logic [VA_W-1:0]    in_pc,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_grant,
  output logic [2:0]         out_fault,
  output logic [VA_W-1:0]    out_addr
);
  localparam int RES_W = 1 + 3 + VA_W;

  logic      grant;
  logic      misaligned;
  fault_e    fault;
  logic      use_pc;
  logic [VA_W-1:0]  rep_addr;
  logic [RES_W-1:0] res_in;
  logic [RES_W-1:0] res_out;

  chk_grant_decode u_grant (
    .el    (in_el),
    .kind  (in_kind),
    .ap    (in_ap),
    .xn    (in_xn),
    .pxn   (in_pxn),
    .wxn   (in_wxn),
    .grant (grant)
  );

  chk_align_probe #(.VA_W(VA_W), .ALIGN_W(ALIGN_W)) u_align (
    .vaddr      (in_vaddr),
    .align      (in_align),
    .misaligned (misaligned)
  );

  chk_fault_rank u_rank (
    .kind       (in_kind),
    .pc_lo      (in_pc[1:0]),
    .misaligned (misaligned),
    .normal     (in_normal),
    .noncache   (in_noncache),
    .prefetch   (in_prefetch),
    .grant      (grant),
    .fault      (fault),
    .use_pc     (use_pc)
  );

  assign rep_addr = use_pc ? in_pc : in_vaddr;
  assign res_in   = {grant, fault, rep_addr};

  chk_out_stage #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign out_grant = res_out[RES_W-1];
  assign out_fault = res_out[RES_W-2 -: 3];
  assign out_addr  = res_out[VA_W-1:0];

  logic in_fire;
  assign in_fire = in_valid && in_ready;

  // R3: kind 3 is never offered
  p_kind_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_kind != 2'd3));

  // R3: level 0 never writes a page with ap[1] set
  p_user_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_el == 2'd0 && in_kind == KIND_WRITE && in_ap[1])
      |=> (out_valid && !out_grant));

  // R9: misaligned PC on fetch wins and reports the PC
  p_pc_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_kind == KIND_EXEC && in_pc[1:0] != 2'b00)
      |=> (out_fault == FLT_PC_ALIGN && out_addr == $past(in_pc)));

  // R8: uncacheable prefetch on an aligned normal read
  p_pf_uncache_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_kind == KIND_READ && in_normal && in_prefetch && in_noncache)
      |=> (out_fault == FLT_PF_UNCACHE && out_addr == $past(in_vaddr)));

  // R7: normal memory never raises an alignment fault
  p_normal_no_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_normal) |=> (out_fault != FLT_ALIGN));
endmodule

// File: tb/test_el_access_checker.sv
`timescale 1ns/100ps
module test_el_access_checker;
  localparam int VA_W    = 48;
  localparam int ALIGN_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [1:0]         in_el = '0;
  logic [1:0]         in_kind = '0;
  logic [1:0]         in_ap = '0;
  logic               in_xn = 1'b0;
  logic               in_pxn = 1'b0;
  logic               in_normal = 1'b1;
  logic               in_noncache = 1'b0;
  logic               in_prefetch = 1'b0;
  logic [ALIGN_W-1:0] in_align = '0;
  logic               in_wxn = 1'b0;
  logic [VA_W-1:0]    in_vaddr = '0;
  logic [VA_W-1:0]    in_pc = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic               out_grant;
  logic [2:0]         out_fault;
  logic [VA_W-1:0]    out_addr;

  el_access_checker #(.VA_W(VA_W), .ALIGN_W(ALIGN_W)) i_el_access_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_el(in_el), .in_kind(in_kind), .in_ap(in_ap), .in_xn(in_xn),
    .in_pxn(in_pxn), .in_normal(in_normal), .in_noncache(in_noncache),
    .in_prefetch(in_prefetch), .in_align(in_align), .in_wxn(in_wxn),
    .in_vaddr(in_vaddr), .in_pc(in_pc), .out_valid(out_valid),
    .out_ready(out_ready), .out_grant(out_grant), .out_fault(out_fault),
    .out_addr(out_addr)
  );

  typedef struct packed {
    logic            grant;
    logic [2:0]      fault;
    logic [VA_W-1:0] addr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // rights {r,w,x} from the requirement tables
  function automatic logic [2:0] rights(input logic [1:0] el, input logic [1:0] ap,
                                        input logic xn, input logic pxn, input logic wxn);
    logic [3:0] idx;
    logic [2:0] r;
    idx = {ap, xn, pxn};
    r = 3'b000;
    if (el == 2'd0) begin
      case (idx)
        4'd0, 4'd1, 4'd8, 4'd9: r = 3'b001;
        4'd4, 4'd5:             r = {2'b11, ~wxn};
        4'd6, 4'd7:             r = 3'b110;
        4'd12, 4'd13:           r = 3'b101;
        4'd14, 4'd15:           r = 3'b100;
        default:                r = 3'b000;
      endcase
    end else if (el == 2'd1) begin
      case (idx)
        4'd0, 4'd2:                          r = {2'b11, ~wxn};
        4'd1, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7:  r = 3'b110;
        4'd8, 4'd10, 4'd12, 4'd14:           r = 3'b101;
        default:                             r = 3'b100;
      endcase
    end else begin
      case ({ap[1], xn})
        2'd0:    r = {2'b11, ~wxn};
        2'd1:    r = 3'b110;
        2'd2:    r = 3'b101;
        default: r = 3'b100;
      endcase
    end
    return r;
  endfunction

  task automatic send(input string tag, input logic [1:0] el, input logic [1:0] kind,
                      input logic [1:0] ap, input logic xn, input logic pxn,
                      input logic normal, input logic nc, input logic pf,
                      input logic [ALIGN_W-1:0] al, input logic wxn,
                      input logic [VA_W-1:0] va, input logic [VA_W-1:0] pc);
    logic [2:0] rw;
    logic g;
    logic unal;
    logic [2:0] f;
    exp_t e;
    rw = rights(el, ap, xn, pxn, wxn);
    g = (kind == 2'd1) ? rw[1] : (kind == 2'd2) ? rw[0] : rw[2];
    unal = ((va % (64'd1 << al)) != 0);
    if (kind == 2'd2 && pc[1:0] != 2'b00)      f = 3'd1;
    else if (kind != 2'd2 && !normal && unal)  f = 3'd2;
    else if (pf && nc)                         f = 3'd3;
    else if (!g)                               f = (kind == 2'd2) ? 3'd4 : 3'd5;
    else                                       f = 3'd0;
    e.grant = g;
    e.fault = f;
    e.addr  = (f == 3'd1 || f == 3'd4) ? pc : va;
    @(negedge clk);
    in_el = el; in_kind = kind; in_ap = ap; in_xn = xn; in_pxn = pxn;
    in_normal = normal; in_noncache = nc; in_prefetch = pf; in_align = al;
    in_wxn = wxn; in_vaddr = va; in_pc = pc; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  // monitor: picks ready for the next edge, compares what that edge takes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic r;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        r = stall_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
        out_ready = r;
        if (out_valid && !r) begin
          #0.5;
          total++;
          if (in_ready !== 1'b0) begin
            bad++;
            $display("FAIL R1 in_ready during stall: got %b expected 0", in_ready);
          end
        end
        if (out_valid && r) begin
          exp_t e;
          string t;
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R1 unexpected result: got grant=%b fault=%0d addr=%h expected none",
                     out_grant, out_fault, out_addr);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (out_grant !== e.grant || out_fault !== e.fault || out_addr !== e.addr) begin
              bad++;
              $display("FAIL %s: got grant=%b fault=%0d addr=%h expected grant=%b fault=%0d addr=%h",
                       t, out_grant, out_fault, out_addr, e.grant, e.fault, e.addr);
            end
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog: run hung, got %0d cycles expected under 20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [VA_W-1:0] va0;
    logic [VA_W-1:0] pc0;
    va0 = 48'h0000_1234_5000;
    pc0 = 48'h0000_8000_0100;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      bad++;
      $display("FAIL R2 reset: got out_valid=%b in_ready=%b expected 0 0", out_valid, in_ready);
    end
    rst_n = 1'b1;

    // table sweep, back-to-back, consumer always ready
    for (int el = 0; el < 4; el++)
      for (int k = 0; k < 3; k++)
        for (int idx = 0; idx < 16; idx++)
          for (int w = 0; w < 2; w++)
            send(el == 0 ? "R3" : el == 1 ? "R4" : "R5", 2'(el), 2'(k),
                 idx[3:2], idx[1], idx[0], 1'b1, 1'b0, 1'b0, 3'd0, w[0],
                 va0 + 48'(idx * 16), pc0);

    // R6: grant still reported under an alignment fault
    send("R6", 2'd1, 2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, va0 + 48'd2, pc0);
    // R7: unaligned device write, aligned device write, unaligned normal, device fetch
    send("R7", 2'd2, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, va0 + 48'd4, pc0);
    send("R7", 2'd2, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, va0 + 48'd8, pc0);
    send("R7", 2'd2, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, va0 + 48'd1, pc0);
    send("R7", 2'd1, 2'd2, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, va0 + 48'd5, pc0);
    // R8: uncacheable prefetch; prefetch to cacheable page is fine
    send("R8", 2'd1, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, va0, pc0);
    send("R8", 2'd1, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, va0, pc0);
    // R9: misaligned PC on fetch; misaligned PC on a read is ignored
    send("R9", 2'd0, 2'd2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, va0, pc0 + 48'd2);
    send("R9", 2'd1, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, va0, pc0 + 48'd1);
    // R10: denied fetch reports PC, denied write reports vaddr
    send("R10", 2'd3, 2'd2, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, va0, pc0 + 48'd4);
    send("R10", 2'd3, 2'd1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, va0 + 48'd64, pc0);
    // R11: collisions
    send("R11", 2'd0, 2'd2, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, va0 + 48'd1, pc0 + 48'd3);
    send("R11", 2'd0, 2'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, va0 + 48'd2, pc0);
    send("R11", 2'd0, 2'd1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, va0, pc0);
    send("R11", 2'd0, 2'd2, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, va0, pc0);

    // R1: traffic under a stalling consumer
    stall_mode = 1'b1;
    for (int n = 0; n < 96; n++)
      send("R1", 2'(n % 4), 2'(n % 3), 2'((n / 3) % 4), n[3], n[4], n[2], n[5], n[6],
           3'(n % 4), n[1], va0 + 48'(n * 3), pc0 + 48'(n * 4));

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule